// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Split 64-bit Accumulator

This block multiplies two 32-bit operands and folds the result into a 64-bit accumulator. The accumulator is held as a high word and a low word. Each operation takes one clock cycle. An operation can add the product, subtract it, or read the low word and clear the whole accumulator. Both halves are always visible on output pins, and a direct write port lets a register file load either half.

Before the product reaches the accumulator it is cut to its low 32 bits. Those bits are read as a signed value and sign-extended to 64 bits. A product that does not fit in 32 signed bits therefore adds a wrapped value, not its true value.

Each request is one cycle with `op_valid` high. The result is in the accumulator at the next rising edge. A request on the following cycle already sees that result, so no stall is needed.

Top module: `mac_accum`

## Requirements
- R1: While `rst_n` is low, and after it is released, both halves of the accumulator read zero and `rd_valid` is low.
- R2: With `op_valid` high and `op_sel` = 2'b01 (accumulate), the accumulator is incremented by the sign-extended low 32 bits of `opnd_a * opnd_b`. The new value is visible on `acc_hi`/`acc_lo` after the next rising edge.
- R3: With `op_valid` high and `op_sel` = 2'b10 (subtract), the same sign-extended truncated product is subtracted from the accumulator.
- R4: With `op_valid` high and `op_sel` = 2'b11 (read-and-clear), the next rising edge puts the old low word on `rd_data`, raises `rd_valid` for one cycle, and sets both halves to zero.
- R5: Operations issued on consecutive cycles each act on the result of the one before. A read-and-clear right after an accumulate returns the accumulated low word.
- R6: If `op_valid` is low, or `op_sel` = 2'b00, the accumulator does not change and `rd_valid` stays low.
- R7: With `reg_wr_en` high, `reg_wr_data` replaces the high half when `reg_wr_hi` = 1 or the low half when `reg_wr_hi` = 0. The other half keeps its value.
- R8: A write on the register port in the same cycle as an operation takes priority. The operation is dropped: no arithmetic, no clear, and no `rd_valid`.
- R9: The 64-bit arithmetic carries from the low half into the high half and borrows from the high half. Results wrap modulo 2^64.
- R10: When the low 32 bits of the product have bit 31 set, the product counts as negative. For example, 0x00010000 * 0x00008000 adds -2^31. Bits of the product above bit 31 are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation request strobe |
| op_sel | input | 2 | 00 none, 01 accumulate, 10 subtract, 11 read-and-clear |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| reg_wr_en | input | 1 | Direct write to one accumulator half |
| reg_wr_hi | input | 1 | 1 selects the high half, 0 the low half |
| reg_wr_data | input | 32 | Data for the direct write |
| rd_data | output | 32 | Low word captured by the last read-and-clear |
| rd_valid | output | 1 | High for the cycle after a read-and-clear |
| acc_hi | output | 32 | High half of the accumulator |
| acc_lo | output | 32 | Low half of the accumulator |

## Verification
The bench builds the unit with its defaults: a 32-bit word and the truncating product variant. These are the settings where the carry between halves, the borrow out of the high half, and sign-extension of a product wrapped to 32 bits can all be reached with small operands. Direct writes preload values such as an all-ones low word or an all-ones accumulator, which puts the carry and wrap boundaries a single multiply away. A pseudo-random mix of operations and writes then checks that issuing operations back to back holds up, and that a write racing an operation is always resolved in favour of the write.

// File: rtl/mac_accum_pkg.sv
package mac_accum_pkg;

   typedef enum logic [1:0] {
      MAC_NONE  = 2'b00,
      MAC_ADD   = 2'b01,
      MAC_SUB   = 2'b10,
      MAC_RDCLR = 2'b11
   } mac_op_e;

   typedef struct packed {
      logic add;
      logic sub;
      logic clr;
   } mac_ctl_t;

endpackage

// File: rtl/mac_accum_product.sv
module mac_accum_product #(
   parameter int W     = 32,
   parameter bit TRUNC = 1'b1
) (
   input  logic [W-1:0]   mul_a,
   input  logic [W-1:0]   mul_b,
   output logic [2*W-1:0] addend
);
   localparam int ACC_W = 2 * W;

   generate
      if (TRUNC) begin : g_trunc
         // the low W product bits do not depend on operand signedness
         logic [W-1:0] low_w;
         assign low_w  = mul_a * mul_b;
         assign addend = {{W{low_w[W-1]}}, low_w};
      end else begin : g_full
         logic [ACC_W-1:0] ext_a, ext_b;
         assign ext_a  = {{W{mul_a[W-1]}}, mul_a};
         assign ext_b  = {{W{mul_b[W-1]}}, mul_b};
         assign addend = ext_a * ext_b;
      end
   endgenerate

endmodule

// File: rtl/mac_accum_decode.sv
module mac_accum_decode
   import mac_accum_pkg::*;
(
   input  logic       op_valid,
   input  logic [1:0] op_sel,
   input  logic       wr_en,
   output mac_ctl_t   ctl
);
   mac_op_e op;
   assign op = mac_op_e'(op_sel);

   always_comb begin
      ctl = '0;
      if (op_valid && !wr_en) begin
         case (op)
            MAC_ADD:   ctl.add = 1'b1;
            MAC_SUB:   ctl.sub = 1'b1;
            MAC_RDCLR: ctl.clr = 1'b1;
            default:   ctl = '0;
         endcase
      end
   end

endmodule

// File: rtl/mac_accum_core.sv
module mac_accum_core
   import mac_accum_pkg::*;
#(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  mac_ctl_t       ctl,
   input  logic [2*W-1:0] addend,
   input  logic           wr_en,
   input  logic           wr_hi,
   input  logic [W-1:0]   wr_data,
   output logic [2*W-1:0] acc_q,
   output logic [W-1:0]   rd_data,
   output logic           rd_valid
);
   localparam int ACC_W = 2 * W;

   logic [ACC_W-1:0] acc_d;

   always_comb begin
      acc_d = acc_q;
      if (wr_en) begin
         if (wr_hi) acc_d[ACC_W-1:W] = wr_data;
         else       acc_d[W-1:0]     = wr_data;
      end else if (ctl.add) begin
         acc_d = acc_q + addend;
      end else if (ctl.sub) begin
         acc_d = acc_q - addend;
      end else if (ctl.clr) begin
         acc_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         acc_q    <= acc_d;
         rd_valid <= ctl.clr;
         if (ctl.clr) rd_data <= acc_q[W-1:0];
      end
   end

   assert_ops_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl.add, ctl.sub, ctl.clr}) && !(wr_en && (ctl.add || ctl.sub || ctl.clr)));

   assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.add |=> acc_q == $past(acc_q) + $past(addend));

   assert_sub_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.sub |=> acc_q == $past(acc_q) - $past(addend));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.clr |=> (acc_q == '0) && rd_valid && (rd_data == $past(acc_q[W-1:0])));

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl.add || ctl.sub || ctl.clr || wr_en) |=> $stable(acc_q) && !rd_valid);

   assert_wr_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi) |=> (acc_q[ACC_W-1:W] == $past(wr_data)) && $stable(acc_q[W-1:0]));

   assert_wr_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi) |=> (acc_q[W-1:0] == $past(wr_data)) && $stable(acc_q[ACC_W-1:W]));

endmodule

// File: rtl/mac_accum.sv
module mac_accum
   import mac_accum_pkg::*;
#(
   parameter int W     = 32,
   parameter bit TRUNC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [1:0]   op_sel,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic         reg_wr_en,
   input  logic         reg_wr_hi,
   input  logic [W-1:0] reg_wr_data,
   output logic [W-1:0] rd_data,
   output logic         rd_valid,
   output logic [W-1:0] acc_hi,
   output logic [W-1:0] acc_lo
);
   localparam int ACC_W = 2 * W;

   generate
      if (W < 2 || W > 64) begin : g_bad_width
         $error("mac_accum: W must lie in 2..64");
      end
   endgenerate

   mac_ctl_t         ctl;
   logic [ACC_W-1:0] addend;
   logic [ACC_W-1:0] acc_q;

   mac_accum_decode u_decode (
      .op_valid (op_valid),
      .op_sel   (op_sel),
      .wr_en    (reg_wr_en),
      .ctl      (ctl)
   );

   mac_accum_product #(.W(W), .TRUNC(TRUNC)) u_product (
      .mul_a  (opnd_a),
      .mul_b  (opnd_b),
      .addend (addend)
   );

   mac_accum_core #(.W(W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .addend   (addend),
      .wr_en    (reg_wr_en),
      .wr_hi    (reg_wr_hi),
      .wr_data  (reg_wr_data),
      .acc_q    (acc_q),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   assign acc_hi = acc_q[ACC_W-1:W];
   assign acc_lo = acc_q[W-1:0];

endmodule

// File: tb/mac_accum_test.sv
module mac_accum_test;

   typedef struct {
      string       tag;
      logic [63:0] acc;
      logic        rdv;
      logic [31:0] rdd;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        reg_wr_en = 1'b0, reg_wr_hi = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] rd_data, acc_hi, acc_lo;
   logic        rd_valid;

   int checks = 0, errors = 0;
   bit done = 0;
   exp_t sb[$];
   logic [63:0] model = '0;

   always #4 clk = ~clk;

   mac_accum uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .reg_wr_en(reg_wr_en),
      .reg_wr_hi(reg_wr_hi), .reg_wr_data(reg_wr_data),
      .rd_data(rd_data), .rd_valid(rd_valid), .acc_hi(acc_hi), .acc_lo(acc_lo)
   );

   function automatic logic [63:0] term(input logic [31:0] a, input logic [31:0] b);
      logic [63:0] p;
      p = {32'd0, a} * {32'd0, b};
      return {{32{p[31]}}, p[31:0]};
   endfunction

   task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic we, input logic whi,
                        input logic [31:0] wd, input string tag);
      exp_t e;
      @(negedge clk);
      op_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
      reg_wr_en = we; reg_wr_hi = whi; reg_wr_data = wd;
      e.rdv = 1'b0; e.rdd = '0;
      if (we) begin
         if (whi) model[63:32] = wd; else model[31:0] = wd;
      end else if (v && op == 2'b01) model = model + term(a, b);
      else if (v && op == 2'b10) model = model - term(a, b);
      else if (v && op == 2'b11) begin
         e.rdv = 1'b1; e.rdd = model[31:0]; model = '0;
      end
      e.acc = model;
      if (tag != "") e.tag = tag;
      else if (we) e.tag = "R7";
      else if (!v || op == 2'b00) e.tag = "R6";
      else if (op == 2'b01) e.tag = "R2";
      else if (op == 2'b10) e.tag = "R3";
      else e.tag = "R4";
      sb.push_back(e);
   endtask

   task automatic op_do(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
      drive(1'b1, op, a, b, 1'b0, 1'b0, '0, tag);
   endtask

   task automatic wr_do(input logic whi, input logic [31:0] wd, input string tag);
      drive(1'b0, 2'b00, '0, '0, 1'b1, whi, wd, tag);
   endtask

   // monitor: pops one expected item per cycle, after the edge settles
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if ({acc_hi, acc_lo} !== e.acc || rd_valid !== e.rdv ||
             (e.rdv && rd_data !== e.rdd)) begin
            errors++;
            $display("FAIL %s: acc=%h rdv=%b rdd=%h expected acc=%h rdv=%b rdd=%h",
                     e.tag, {acc_hi, acc_lo}, rd_valid, rd_data, e.acc, e.rdv, e.rdd);
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2345;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if ({acc_hi, acc_lo} !== 64'd0 || rd_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: acc=%h rdv=%b expected acc=0 rdv=0", {acc_hi, acc_lo}, rd_valid);
      end
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      checks++;
      if ({acc_hi, acc_lo} !== 64'd0 || rd_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: acc=%h rdv=%b expected acc=0 rdv=0", {acc_hi, acc_lo}, rd_valid);
      end

      op_do(2'b01, 32'd3, 32'd4, "R2");
      op_do(2'b01, 32'hFFFF_FFFB, 32'd7, "R2");
      op_do(2'b11, '0, '0, "R5");                 // read right after accumulate
      op_do(2'b10, 32'd6, 32'd7, "R3");
      op_do(2'b01, 32'h0001_0000, 32'h0000_8000, "R10");
      op_do(2'b01, 32'h0003_0000, 32'h0001_0000, "R10");  // low word zero
      op_do(2'b01, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R10");  // low word one
      op_do(2'b11, '0, '0, "R4");
      op_do(2'b11, '0, '0, "R4");                 // read of empty accumulator
      wr_do(1'b0, 32'hFFFF_FFFF, "R7");
      op_do(2'b01, 32'd1, 32'd1, "R9");           // carry into high half
      op_do(2'b10, 32'd1, 32'd1, "R9");           // borrow from high half
      op_do(2'b10, 32'd0, 32'd5, "R3");
      drive(1'b1, 2'b01, 32'd2, 32'd3, 1'b1, 1'b1, 32'h7FFF_FFFF, "R8");
      drive(1'b1, 2'b11, '0, '0, 1'b1, 1'b0, 32'h1234_5678, "R8");
      drive(1'b1, 2'b10, 32'd9, 32'd9, 1'b1, 1'b0, 32'h0BAD_F00D, "R8");
      drive(1'b0, 2'b01, 32'd5, 32'd5, 1'b0, 1'b0, '0, "R6");
      drive(1'b1, 2'b00, 32'd5, 32'd5, 1'b0, 1'b0, '0, "R6");
      drive(1'b0, 2'b11, '0, '0, 1'b0, 1'b0, '0, "R6");
      wr_do(1'b1, 32'hFFFF_FFFF, "R7");
      wr_do(1'b0, 32'hFFFF_FFFF, "R7");
      op_do(2'b01, 32'd1, 32'd1, "R9");           // wraps to zero
      op_do(2'b10, 32'd2, 32'd1, "R9");           // wraps below zero
      op_do(2'b01, 32'd10, 32'd10, "R5");
      op_do(2'b01, 32'd20, 32'd20, "R5");
      op_do(2'b10, 32'd5, 32'd6, "R5");
      op_do(2'b11, '0, '0, "R5");

      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         drive(lfsr[3] | lfsr[7], lfsr[1:0], lfsr ^ 32'h5A5A_0F0F,
               {lfsr[15:0], lfsr[31:16]}, (lfsr[6:4] == 3'b000), lfsr[9],
               ~lfsr, "");
      end
      drive(1'b0, 2'b00, '0, '0, 1'b0, 1'b0, '0, "");
      while (sb.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1;
      finish_run();
   end

endmodule